// File: doc/BRIEF.md
# Direct-Colour Pixel Byte Assembler

This block sits between a graphics controller's byte-wide pixel data path and the colour output stage. Bytes arrive on an 8-bit bus, each qualified by one of two strobes. The rise strobe marks a byte taken on the rising phase of the pixel clock. The fall strobe marks a byte taken on the falling phase; it models double-edge capture as a plain synchronous event. Static configuration inputs pick the colour depth and the capture scheme. The block gathers the bytes of one pixel, unpacks the red, green and blue fields, widens each to 8 bits and presents them as one RGB888 word with a one-cycle valid pulse.

When direct colour is disabled, every byte is a palette index. It comes out on the blue channel, with red and green at zero, so that a later lookup stage can use it. A blanking input drops any partly gathered pixel, so the first byte after blanking always starts a new pixel. The configuration inputs may only change while no pixel is partly gathered, for example during blanking.

Top module: `dcpix_assembler`

## Requirements
- R1: After a reset cycle, `pix_valid` is 0 and `red`, `green` and `blue` are all zero.
- R2: With `cfg_direct` at 0, each byte taken on `byte_rise` produces a pixel with `blue` equal to the byte and `red` = `green` = 0. A byte on `byte_fall` alone produces nothing.
- R3: With `cfg_depth` = 2'b00 (15-bit), the assembled word carries blue in bits 4:0, green in bits 9:5 and red in bits 14:10. Each 5-bit field widens to 8 bits as {field, field[4:2]}.
- R4: With `cfg_depth` = 2'b01 (16-bit), blue is bits 4:0, green is bits 10:5 (6 bits) and red is bits 15:11. Green widens as {field, field[5:4]} and the 5-bit fields widen as in R3.
- R5: With `cfg_depth[1]` = 1 (24-bit), a pixel takes three bytes. Blue is bits 7:0, green is bits 15:8 and red is bits 23:16, with no widening.
- R6: Multi-byte pixels are little-endian. The first byte of a pixel is bits 7:0 of the word, the second is bits 15:8 and the third is bits 23:16.
- R7: With `cfg_two_clk` = 1, bytes are taken only on `byte_rise`, one per strobe cycle, and `byte_fall` is ignored.
- R8: With `cfg_two_clk` = 0 and direct colour on, the byte positions of a pixel alternate between rise and fall. Position 0 is taken on `byte_rise`, position 1 on `byte_fall` and position 2 on `byte_rise`. A strobe of the other kind is ignored.
- R9: In 15-bit mode, bit 15 of the assembled word has no effect on the output.
- R10: While `blank` is 1, no byte is taken and any partly gathered pixel is dropped. The next byte taken is position 0.
- R11: `pix_valid` is high for exactly one cycle. It is the cycle after the clock edge that takes the last byte of a pixel. It stays low after the earlier bytes of the pixel.
- R12: If both strobes are high in one cycle, the byte is taken once, as the strobe the current position expects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_direct | input | 1 | 1: direct colour, 0: bytes are palette indices |
| cfg_depth | input | 2 | 00: 15-bit, 01: 16-bit, 1x: 24-bit |
| cfg_two_clk | input | 1 | 1: one byte per rising strobe, 0: alternate rise/fall strobes |
| blank | input | 1 | Blanking; drops a partly gathered pixel |
| byte_in | input | 8 | Pixel data byte |
| byte_rise | input | 1 | Byte on the rising phase |
| byte_fall | input | 1 | Byte on the falling phase |
| pix_valid | output | 1 | One-cycle pulse per completed pixel |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel (index in palette mode) |

## Verification
A byte-position counter that is out of step shows on the very next pixel. The colour fields come out rotated by a byte, or `pix_valid` fires one byte early or late, so the error appears within one pixel time. A bad stored byte corrupts only the channels that draw from it, and always in the cycle right after the last byte. Blanking and ignored-strobe cases are checked by sending a complete pixel straight after the disturbance. A hidden phase error therefore surfaces as wrong colours on that pixel.

// File: rtl/dcpix_pkg.sv
// Shared types and colour-widening helpers for the pixel byte assembler.
// Assumes 8-bit output channels.
package dcpix_pkg;
    localparam int CH_W = 8;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Widen a 5-bit field by repeating its top bits below it.
    function automatic logic [CH_W-1:0] widen5(input logic [4:0] f);
        return {f, f[4:2]};
    endfunction

    // Widen a 6-bit field by repeating its top bits below it.
    function automatic logic [CH_W-1:0] widen6(input logic [5:0] f);
        return {f, f[5:4]};
    endfunction
endpackage

// File: rtl/dcpix_phase_ctrl.sv
// Byte-position tracker. It decides which strobe the current position
// expects, whether the byte is taken and whether it completes a pixel.
// Assumes the configuration is steady while a pixel is partly gathered.
module dcpix_phase_ctrl #(
    parameter int MAX_BYTES = 3,
    localparam int PH_W = $clog2(MAX_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blank,
    input  logic            cfg_direct,
    input  logic [1:0]      cfg_depth,
    input  logic            cfg_two_clk,
    input  logic            byte_rise,
    input  logic            byte_fall,
    output logic            take,
    output logic            last,
    output logic [PH_W-1:0] phase
);
    logic [PH_W-1:0] need_m1;
    logic            want_fall;

    // Index of the final byte for the active mode.
    always_comb begin
        if (!cfg_direct)       need_m1 = PH_W'(0);
        else if (cfg_depth[1]) need_m1 = PH_W'(MAX_BYTES - 1);
        else                   need_m1 = PH_W'(1);
    end

    // Strobe selection and take/last decode.
    always_comb begin
        want_fall = cfg_direct && !cfg_two_clk && phase[0];
        take      = !blank && (want_fall ? byte_fall : byte_rise);
        last      = take && (phase == need_m1);
    end

    // Position counter: cleared by reset or blanking, wraps after last byte.
    always_ff @(posedge clk) begin
        if (!rst_n || blank) phase <= '0;
        else if (take)       phase <= last ? '0 : phase + PH_W'(1);
    end
endmodule

// File: rtl/dcpix_byte_store.sv
// Holds the earlier bytes of a pixel until its last byte arrives.
// One register per non-final byte position, built by a generate loop.
module dcpix_byte_store #(
    parameter int MAX_BYTES = 3,
    parameter int BYTE_W = 8,
    localparam int PH_W = $clog2(MAX_BYTES),
    localparam int HELD = MAX_BYTES - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [PH_W-1:0]       phase,
    input  logic [BYTE_W-1:0]     byte_in,
    output logic [HELD*BYTE_W-1:0] held
);
    for (genvar i = 0; i < HELD; i++) begin : g_slot
        // Load slot i when the byte at position i is taken.
        always_ff @(posedge clk) begin
            if (!rst_n) held[i*BYTE_W +: BYTE_W] <= '0;
            else if (take && phase == PH_W'(i))
                held[i*BYTE_W +: BYTE_W] <= byte_in;
        end
    end
endmodule

// File: rtl/dcpix_unpack.sv
// Splits an assembled little-endian word into widened RGB888 channels.
// Purely combinational; the word's unused upper bits are ignored.
module dcpix_unpack
    import dcpix_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              cfg_direct,
    input  logic [1:0]        cfg_depth,
    input  logic [WORD_W-1:0] word,
    output rgb_t              rgb
);
    // Field extraction per mode.
    always_comb begin
        if (!cfg_direct) begin
            rgb = '{r: '0, g: '0, b: word[7:0]};
        end else if (cfg_depth[1]) begin
            rgb = '{r: word[23:16], g: word[15:8], b: word[7:0]};
        end else if (cfg_depth[0]) begin
            rgb = '{r: widen5(word[15:11]), g: widen6(word[10:5]), b: widen5(word[4:0])};
        end else begin
            rgb = '{r: widen5(word[14:10]), g: widen5(word[9:5]), b: widen5(word[4:0])};
        end
    end
endmodule

// File: rtl/dcpix_assembler.sv
// Top of the pixel byte assembler. It gathers 1, 2 or 3 bytes per pixel
// under the configured capture scheme and registers the widened RGB
// result, with a valid pulse in the cycle after the last byte is taken.
// Assumes cfg_* change only while no pixel is partly gathered.
module dcpix_assembler
    import dcpix_pkg::*;
#(
    parameter int MAX_BYTES = 3,
    parameter int BYTE_W = 8,
    localparam int PH_W = $clog2(MAX_BYTES),
    localparam int WORD_W = MAX_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_direct,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_two_clk,
    input  logic              blank,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_rise,
    input  logic              byte_fall,
    output logic              pix_valid,
    output logic [CH_W-1:0]   red,
    output logic [CH_W-1:0]   green,
    output logic [CH_W-1:0]   blue
);
    logic                         take, last;
    logic [PH_W-1:0]              phase;
    logic [(MAX_BYTES-1)*BYTE_W-1:0] held;
    logic [WORD_W-1:0]            word;
    rgb_t                         rgb_next;

    dcpix_phase_ctrl #(.MAX_BYTES(MAX_BYTES)) u_phase (
        .clk(clk), .rst_n(rst_n), .blank(blank),
        .cfg_direct(cfg_direct), .cfg_depth(cfg_depth), .cfg_two_clk(cfg_two_clk),
        .byte_rise(byte_rise), .byte_fall(byte_fall),
        .take(take), .last(last), .phase(phase)
    );

    dcpix_byte_store #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .take(take), .phase(phase),
        .byte_in(byte_in), .held(held)
    );

    // Place the final byte above the held ones according to pixel size.
    always_comb begin
        word = '0;
        if (!cfg_direct)       word[BYTE_W-1:0] = byte_in;
        else if (cfg_depth[1]) word = {byte_in, held};
        else                   word[2*BYTE_W-1:0] = {byte_in, held[BYTE_W-1:0]};
    end

    dcpix_unpack #(.WORD_W(WORD_W)) u_unpack (
        .cfg_direct(cfg_direct), .cfg_depth(cfg_depth),
        .word(word), .rgb(rgb_next)
    );

    // Output register: pulse valid and load colours on pixel completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            red       <= '0;
            green     <= '0;
            blue      <= '0;
        end else begin
            pix_valid <= last;
            if (last) begin
                red   <= rgb_next.r;
                green <= rgb_next.g;
                blue  <= rgb_next.b;
            end
        end
    end
endmodule

// File: rtl/dcpix_checker.sv
// Port-level properties of the pixel byte assembler, bound to the top.
module dcpix_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_direct,
    input logic [1:0] cfg_depth,
    input logic       cfg_two_clk,
    input logic       blank,
    input logic       byte_rise,
    input logic       byte_fall,
    input logic       pix_valid,
    input logic [7:0] red,
    input logic [7:0] green,
    input logic [7:0] blue
);
    // Reset leaves the output quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && red == 8'h0 && green == 8'h0 && blue == 8'h0));

    // Palette mode carries nothing on red or green.
    a_r2_index_blue_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !$past(cfg_direct)) |-> (red == 8'h0 && green == 8'h0));

    // 15-bit widening repeats each field's top bits.
    a_r3_widen5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(cfg_direct) && $past(cfg_depth) == 2'b00)
        |-> (red[2:0] == red[7:5] && green[2:0] == green[7:5] && blue[2:0] == blue[7:5]));

    // 16-bit green widening repeats its top two bits.
    a_r4_widen6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(cfg_direct) && $past(cfg_depth) == 2'b01)
        |-> (green[1:0] == green[7:6] && red[2:0] == red[7:5]));

    // A lone fall strobe in two-clock mode completes nothing.
    a_r7_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_direct && cfg_two_clk && byte_fall && !byte_rise) |=> !pix_valid);

    // Nothing completes from a blanked cycle.
    a_r10_blank_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !pix_valid);

    // No strobe, no pixel.
    a_r11_no_strobe_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_rise && !byte_fall) |=> !pix_valid);
endmodule

bind dcpix_assembler dcpix_checker u_dcpix_checker (
    .clk(clk), .rst_n(rst_n), .cfg_direct(cfg_direct), .cfg_depth(cfg_depth),
    .cfg_two_clk(cfg_two_clk), .blank(blank), .byte_rise(byte_rise),
    .byte_fall(byte_fall), .pix_valid(pix_valid), .red(red),
    .green(green), .blue(blue)
);

// File: tb/tb_dcpix_assembler.sv
`timescale 1ns/1ps
module tb_dcpix_assembler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_direct = 1'b1;
    logic [1:0] cfg_depth = 2'b00;
    logic       cfg_two_clk = 1'b1;
    logic       blank = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_rise = 1'b0;
    logic       byte_fall = 1'b0;
    logic       pix_valid;
    logic [7:0] red, green, blue;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dcpix_assembler dut (
        .clk(clk), .rst_n(rst_n), .cfg_direct(cfg_direct), .cfg_depth(cfg_depth),
        .cfg_two_clk(cfg_two_clk), .blank(blank), .byte_in(byte_in),
        .byte_rise(byte_rise), .byte_fall(byte_fall), .pix_valid(pix_valid),
        .red(red), .green(green), .blue(blue)
    );

    // {direct, depth, two_clk, b0, b1, b2, expected rgb}
    localparam int NV = 12;
    localparam logic [51:0] VEC [NV] = '{
        {1'b1, 2'b00, 1'b1, 8'hFF, 8'h7F, 8'h00, 24'hFFFFFF},
        {1'b1, 2'b00, 1'b1, 8'h00, 8'h80, 8'h00, 24'h000000},
        {1'b1, 2'b00, 1'b0, 8'h00, 8'h7C, 8'h00, 24'hFF0000},
        {1'b1, 2'b00, 1'b1, 8'hE0, 8'h03, 8'h00, 24'h00FF00},
        {1'b1, 2'b00, 1'b0, 8'h1F, 8'h00, 8'h00, 24'h0000FF},
        {1'b1, 2'b00, 1'b1, 8'h35, 8'h40, 8'h00, 24'h8408AD},
        {1'b1, 2'b01, 1'b1, 8'h00, 8'hF8, 8'h00, 24'hFF0000},
        {1'b1, 2'b01, 1'b0, 8'hE0, 8'h07, 8'h00, 24'h00FF00},
        {1'b1, 2'b01, 1'b1, 8'h27, 8'h54, 8'h00, 24'h528639},
        {1'b1, 2'b10, 1'b1, 8'h11, 8'h22, 8'h33, 24'h332211},
        {1'b1, 2'b10, 1'b0, 8'hA5, 8'h5A, 8'hC3, 24'hC35AA5},
        {1'b0, 2'b00, 1'b1, 8'h9C, 8'h00, 8'h00, 24'h00009C}
    };

    task automatic check(input bit ok, input string tag, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check a completed pixel: valid high and colours as expected.
    task automatic check_pix(input string tag, input logic [23:0] exp);
        check(pix_valid === 1'b1 && {red, green, blue} === exp, tag,
              {pix_valid, red, green, blue}, {1'b1, exp});
    endtask

    task automatic check_idle(input string tag);
        check(pix_valid === 1'b0, tag, {24'h0, pix_valid}, 25'h0);
    endtask

    // Present one byte with the given strobes for one cycle; return at the
    // falling edge after the capturing rising edge.
    task automatic put(input logic [7:0] d, input bit r, input bit f, input bit blk);
        @(negedge clk);
        byte_in = d; byte_rise = r; byte_fall = f; blank = blk;
        @(negedge clk);
        byte_rise = 1'b0; byte_fall = 1'b0; blank = 1'b0;
    endtask

    task automatic set_mode(input bit dir, input logic [1:0] dep, input bit two);
        cfg_direct = dir; cfg_depth = dep; cfg_two_clk = two;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pix_valid === 1'b0 && {red, green, blue} === 24'h0, "R1 reset",
              {pix_valid, red, green, blue}, 25'h0);
        rst_n = 1'b1;

        // Table: R2 R3 R4 R5 R6 R8 R9 R11 across modes
        for (int v = 0; v < NV; v++) begin
            logic [51:0] e;
            int n;
            logic [7:0] bytes [3];
            e = VEC[v];
            set_mode(e[51], e[50:49], e[48]);
            bytes[0] = e[47:40]; bytes[1] = e[39:32]; bytes[2] = e[31:24];
            n = !e[51] ? 1 : (e[50] ? 3 : 2);
            for (int i = 0; i < n; i++) begin
                bit r, f;
                r = e[48] || (i % 2 == 0);
                f = !e[48] && (i % 2 == 1);
                put(bytes[i], r, f, 1'b0);
                if (i < n - 1) check_idle($sformatf("R11 early byte vec%0d", v));
            end
            check_pix($sformatf("R3/R4/R5/R6/R9 vec%0d", v), e[23:0]);
        end

        // R11: pulse lasts one cycle
        @(negedge clk);
        check_idle("R11 single pulse");

        // R7: fall strobe ignored in two-clock mode
        set_mode(1'b1, 2'b01, 1'b1);
        put(8'h27, 1'b1, 1'b0, 1'b0);
        put(8'hFF, 1'b0, 1'b1, 1'b0);
        check_idle("R7 fall ignored");
        put(8'h54, 1'b1, 1'b0, 1'b0);
        check_pix("R7 pixel after ignored fall", 24'h528639);

        // R8: rise at fall position ignored in double-edge mode
        set_mode(1'b1, 2'b01, 1'b0);
        put(8'h27, 1'b1, 1'b0, 1'b0);
        put(8'hFF, 1'b1, 1'b0, 1'b0);
        check_idle("R8 wrong strobe ignored");
        put(8'h54, 1'b0, 1'b1, 1'b0);
        check_pix("R8 pixel after wrong strobe", 24'h528639);

        // R12: both strobes together, taken once per position
        put(8'h27, 1'b1, 1'b1, 1'b0);
        check_idle("R12 both strobes low byte");
        put(8'h54, 1'b1, 1'b1, 1'b0);
        check_pix("R12 both strobes pixel", 24'h528639);

        // R10: blanking drops a partial pixel and the blanked byte
        set_mode(1'b1, 2'b01, 1'b1);
        put(8'hAA, 1'b1, 1'b0, 1'b0);
        put(8'hFF, 1'b1, 1'b0, 1'b1);
        check_idle("R10 blank no pixel");
        put(8'h27, 1'b1, 1'b0, 1'b0);
        check_idle("R10 restart at low byte");
        put(8'h54, 1'b1, 1'b0, 1'b0);
        check_pix("R10 pixel after blank", 24'h528639);

        // R2: lone fall strobe in palette mode does nothing
        set_mode(1'b0, 2'b00, 1'b1);
        put(8'h42, 1'b0, 1'b1, 1'b0);
        check_idle("R2 index fall ignored");
        put(8'h42, 1'b1, 1'b0, 1'b0);
        check_pix("R2 index byte", 24'h000042);

        // R1: reset mid-pixel clears output and position
        set_mode(1'b1, 2'b01, 1'b1);
        put(8'hAA, 1'b1, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(pix_valid === 1'b0 && {red, green, blue} === 24'h0, "R1 reset mid-pixel",
              {pix_valid, red, green, blue}, 25'h0);
        rst_n = 1'b1;
        put(8'h27, 1'b1, 1'b0, 1'b0);
        put(8'h54, 1'b1, 1'b0, 1'b0);
        check_pix("R1 pixel after reset", 24'h528639);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule